// File: doc/BRIEF.md
# Steerable Sum-of-Products Array

This block is a configurable two-level logic array for the logic slice of a programmable device. Thirty-six routed signals enter and each is offered to a programmable AND plane in both its true and its inverted form, which gives 72 literal columns. The AND plane forms a shared pool of 86 product terms. A steering stage then ORs any chosen subset of that pool into each of 16 sum outputs, and those sums feed the macrocells. A single product term may be summed into several outputs at once, so logic common to more than one output is built only once. From the routed inputs to the sums the path is purely combinational and its depth does not depend on the configuration.

The configuration is a flat image of 7568 bits. It is shifted in one bit per clock while a shift enable is high, into a shadow register that does not touch the live logic. A one-cycle load strobe asks for the image to be applied. During the cycle after the strobe every steering mask in the shadow image is checked. If every mask selects 16 terms or fewer, the whole image is copied into the live configuration and the error flag clears. Otherwise the whole image is refused, the live configuration stays as it was and the error flag is set.

The configuration controller has three states. `ST_IDLE` waits. It moves to `ST_SHIFT` when the shift enable is seen, and to `ST_CHECK` when the load strobe is seen. `ST_SHIFT` moves to `ST_CHECK` on the load strobe, and back to `ST_IDLE` when the shift enable drops. `ST_CHECK` lasts exactly one cycle: it either commits the image or refuses it, then returns to `ST_IDLE`.

Top module: `sop_pt_block`

## Requirements
- R1: Literal 2*i is input i and literal 2*i+1 is its inverse. A product term is the AND of its enabled literals. A term with no literal enabled evaluates to 1.
- R2: A product term that enables both literals of the same input evaluates to 0 for every input value.
- R3: Each sum output is the OR of the product terms selected by its steering mask. An output whose mask is empty drives 0.
- R4: One product term selected in several masks drives all of those outputs at the same time.
- R5: The sums follow a change on `pt_in` with no clock edge in between.
- R6: Configuration bits enter LSB-first: the first bit shifted becomes image bit 0. Image bit k*72+j enables literal j of term k. Image bit 6192+o*86+k selects term k into output o.
- R7: Shifting alone never changes the outputs. With the load strobe sampled at clock edge E, the outputs still show the old configuration after E and show the new one after edge E+1.
- R8: If any steering mask in the shadow image selects more than 16 terms, the load is refused as a whole: `cfg_err` goes to 1 and the outputs keep the previous configuration. A mask with exactly 16 terms is accepted.
- R9: An accepted load clears `cfg_err` to 0. `cfg_err` changes only at the end of `ST_CHECK`.
- R10: After reset every output is 0 and `cfg_err` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pt_in | input | 36 | Routed input signals |
| cfg_shift_en | input | 1 | Shift one configuration bit per clock while high |
| cfg_sdi | input | 1 | Serial configuration data, image bit 0 first |
| cfg_load | input | 1 | One-cycle strobe that requests check and commit |
| cfg_err | output | 1 | Set when the last load was refused |
| sum_out | output | 16 | Sum-of-products outputs |

## Verification
The assertions assume that `cfg_load` arrives as a single-cycle pulse outside `ST_CHECK`. They also assume that shifting and loading are driven only on the configuration clock, and that the routed inputs may change at any time. The stimulus meets these assumptions in three ways. It drives every control input on the falling clock edge. It drops `cfg_shift_en` before it raises the load strobe. It holds the strobe for exactly one cycle. The input vectors are applied between edges, because the sums must react without a clock.

// File: rtl/sop_pkg.sv
package sop_pkg;

    // Configuration controller states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_CHECK = 2'd2
    } cfg_state_e;

    // Literal column of the true form of input i; the inverse sits one above
    function automatic int lit_true_col(input int i);
        return 2 * i;
    endfunction

endpackage

// File: rtl/sop_and_plane.sv
module sop_and_plane
    import sop_pkg::*;
#(
    parameter int N_IN = 36,
    parameter int N_PT = 86
) (
    input  logic [N_IN-1:0]          in_sig,
    input  logic [2*N_IN*N_PT-1:0]   and_cfg,
    output logic [N_PT-1:0]          pt
);
    localparam int LITS = 2 * N_IN;

    logic [LITS-1:0] lits;

    // Literal columns: true then inverted form of each input
    for (genvar i = 0; i < N_IN; i++) begin : g_lit
        assign lits[lit_true_col(i)]     = in_sig[i];
        assign lits[lit_true_col(i) + 1] = ~in_sig[i];
    end

    // A literal that is not enabled forces a 1 into the AND, so an empty term is 1
    for (genvar k = 0; k < N_PT; k++) begin : g_term
        assign pt[k] = &(~and_cfg[k*LITS +: LITS] | lits);
    end

endmodule

// File: rtl/sop_or_steer.sv
module sop_or_steer #(
    parameter int N_PT  = 86,
    parameter int N_OUT = 16
) (
    input  logic [N_PT-1:0]        pt,
    input  logic [N_OUT*N_PT-1:0]  mask,
    output logic [N_OUT-1:0]       sum
);
    // Every output has its own mask over the whole shared pool
    for (genvar o = 0; o < N_OUT; o++) begin : g_sum
        assign sum[o] = |(pt & mask[o*N_PT +: N_PT]);
    end

endmodule

// File: rtl/sop_cfg_ctrl.sv
module sop_cfg_ctrl
    import sop_pkg::*;
#(
    parameter int N_IN   = 36,
    parameter int N_PT   = 86,
    parameter int N_OUT  = 16,
    parameter int MAX_PT = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         shift_en,
    input  logic                         sdi,
    input  logic                         load,
    output logic [2*N_IN*N_PT-1:0]       and_act,
    output logic [N_OUT*N_PT-1:0]        mask_act,
    output logic                         err
);
    localparam int LITS       = 2 * N_IN;
    localparam int AND_BITS   = LITS * N_PT;
    localparam int STEER_BITS = N_OUT * N_PT;
    localparam int CFG_BITS   = AND_BITS + STEER_BITS;

    cfg_state_e          state, state_nxt;
    logic [CFG_BITS-1:0] shadow;
    logic [N_OUT-1:0]    mask_over;
    logic                shift_do;

    // Shadow chain: new bit enters at the top, so the first bit ends at bit 0
    assign shift_do = shift_en && !load && (state != ST_CHECK);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            shadow <= '0;
        else if (shift_do)
            shadow <= {sdi, shadow[CFG_BITS-1:1]};
    end

    // Per-output term count against the limit
    for (genvar o = 0; o < N_OUT; o++) begin : g_cnt
        assign mask_over[o] = ($countones(shadow[AND_BITS + o*N_PT +: N_PT]) > MAX_PT);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nxt;
    end

    // Next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (load)          state_nxt = ST_CHECK;
                else if (shift_en) state_nxt = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (load)           state_nxt = ST_CHECK;
                else if (!shift_en) state_nxt = ST_IDLE;
            end
            ST_CHECK: state_nxt = ST_IDLE;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    // Outputs: live configuration and error flag, written only in ST_CHECK
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            and_act  <= '0;
            mask_act <= '0;
            err      <= 1'b0;
        end else if (state == ST_CHECK) begin
            if (|mask_over) begin
                err <= 1'b1;
            end else begin
                err      <= 1'b0;
                and_act  <= shadow[AND_BITS-1:0];
                mask_act <= shadow[CFG_BITS-1:AND_BITS];
            end
        end
    end

    // R9
    err_only_in_check_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_CHECK) |=> $stable(err));

    // R7
    live_cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_CHECK) |=> ($stable(mask_act) && $stable(and_act)));

    // R8
    reject_keeps_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHECK && |mask_over) |=> ($stable(mask_act) && err));

    // R7
    load_enters_check_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && state != ST_CHECK) |=> (state == ST_CHECK));

    // R8
    for (genvar o = 0; o < N_OUT; o++) begin : g_lim_chk
        live_mask_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($countones(mask_act[o*N_PT +: N_PT]) <= MAX_PT));
    end

endmodule

// File: rtl/sop_pt_block.sv
module sop_pt_block #(
    parameter int N_IN   = 36,
    parameter int N_PT   = 86,
    parameter int N_OUT  = 16,
    parameter int MAX_PT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IN-1:0]   pt_in,
    input  logic              cfg_shift_en,
    input  logic              cfg_sdi,
    input  logic              cfg_load,
    output logic              cfg_err,
    output logic [N_OUT-1:0]  sum_out
);
    localparam int AND_BITS   = 2 * N_IN * N_PT;
    localparam int STEER_BITS = N_OUT * N_PT;

    logic [AND_BITS-1:0]   and_act;
    logic [STEER_BITS-1:0] mask_act;
    logic [N_PT-1:0]       pt;

    sop_cfg_ctrl #(
        .N_IN(N_IN), .N_PT(N_PT), .N_OUT(N_OUT), .MAX_PT(MAX_PT)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (cfg_shift_en),
        .sdi      (cfg_sdi),
        .load     (cfg_load),
        .and_act  (and_act),
        .mask_act (mask_act),
        .err      (cfg_err)
    );

    sop_and_plane #(.N_IN(N_IN), .N_PT(N_PT)) u_and (
        .in_sig  (pt_in),
        .and_cfg (and_act),
        .pt      (pt)
    );

    sop_or_steer #(.N_PT(N_PT), .N_OUT(N_OUT)) u_or (
        .pt   (pt),
        .mask (mask_act),
        .sum  (sum_out)
    );

    // R3
    for (genvar o = 0; o < N_OUT; o++) begin : g_zero_chk
        empty_mask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mask_act[o*N_PT +: N_PT] == '0) |-> (sum_out[o] == 1'b0));
    end

endmodule

// File: tb/sop_pt_block_tb.sv
module sop_pt_block_tb;
    localparam int NI = 36;
    localparam int NP = 86;
    localparam int NO = 16;
    localparam int LITS = 2 * NI;
    localparam int AND_BITS = LITS * NP;
    localparam int CFG_BITS = AND_BITS + NO * NP;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NI-1:0] pt_in = '0;
    logic cfg_shift_en = 1'b0;
    logic cfg_sdi = 1'b0;
    logic cfg_load = 1'b0;
    logic cfg_err;
    logic [NO-1:0] sum_out;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    logic [LITS-1:0] acfg [NP];
    logic [NP-1:0]   mcfg [NO];

    // {input, expected sums} for configuration A
    localparam logic [51:0] VEC [9] = '{
        {36'h0_0000_0000, 16'h0082},
        {36'h0_0000_0001, 16'h009B},
        {36'h0_0000_0003, 16'h0082},
        {36'h8_0000_0000, 16'h808A},
        {36'h0_0000_0040, 16'h80A2},
        {36'h0_0000_0060, 16'h0082},
        {36'hF_FFFF_FFFF, 16'h808A},
        {36'h8_0000_0041, 16'h80BB},
        {36'h0_0000_0004, 16'h0082}
    };

    sop_pt_block u_dut (
        .clk(clk), .rst_n(rst_n), .pt_in(pt_in),
        .cfg_shift_en(cfg_shift_en), .cfg_sdi(cfg_sdi), .cfg_load(cfg_load),
        .cfg_err(cfg_err), .sum_out(sum_out)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Configuration A, layout as in R6
    task automatic build_a();
        for (int k = 0; k < NP; k++) acfg[k] = '0;
        for (int o = 0; o < NO; o++) mcfg[o] = '0;
        acfg[0][0] = 1'b1;  acfg[0][3] = 1'b1;       // in0 & ~in1
        acfg[2][4] = 1'b1;  acfg[2][5] = 1'b1;       // in2 & ~in2 -> 0
        acfg[3][70] = 1'b1;                          // in35
        acfg[85][11] = 1'b1; acfg[85][12] = 1'b1;    // ~in5 & in6
        mcfg[0][0] = 1'b1;
        mcfg[1][1] = 1'b1;                           // empty term -> 1
        mcfg[2][2] = 1'b1;
        mcfg[3][0] = 1'b1;  mcfg[3][3] = 1'b1;
        mcfg[4][0] = 1'b1;
        mcfg[5][85] = 1'b1;
        for (int k = 10; k < 26; k++) mcfg[7][k] = 1'b1;   // exactly 16
        mcfg[15][3] = 1'b1; mcfg[15][85] = 1'b1;
    endtask

    task automatic shift_image();
        logic [CFG_BITS-1:0] img;
        for (int k = 0; k < NP; k++)
            for (int j = 0; j < LITS; j++) img[k*LITS + j] = acfg[k][j];
        for (int o = 0; o < NO; o++)
            for (int k = 0; k < NP; k++) img[AND_BITS + o*NP + k] = mcfg[o][k];
        for (int b = 0; b < CFG_BITS; b++) begin
            @(negedge clk);
            cfg_shift_en = 1'b1;
            cfg_sdi = img[b];
        end
        @(negedge clk);
        cfg_shift_en = 1'b0;
        cfg_sdi = 1'b0;
    endtask

    task automatic pulse_load();
        @(negedge clk);
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R10 sums after reset", 32'(sum_out), 32'h0);
        check("R10 err after reset", 32'(cfg_err), 32'h0);
        rst_n = 1'b1;

        build_a();
        shift_image();
        #1;
        check("R7 shifting alone leaves sums", 32'(sum_out), 32'h0);
        pulse_load();
        #1;
        check("R7 old cfg one edge after load", 32'(sum_out), 32'h0);
        @(negedge clk);
        #1;
        check("R7 new cfg two edges after load", 32'(sum_out), 32'h0082);
        check("R9 err after good load", 32'(cfg_err), 32'h0);

        // Table walk: R1 R2 R3 R4 R6
        for (int v = 0; v < 9; v++) begin
            pt_in = VEC[v][51:16];
            #2;
            check("R1/R2/R3/R4/R6 vector", 32'(sum_out), 32'(VEC[v][15:0]));
        end

        // R5: mid-cycle change, no clock edge
        @(posedge clk);
        #3;
        pt_in = 36'h0_0000_0001;
        #1;
        check("R5 combinational follow", 32'(sum_out), 32'h009B);
        pt_in = 36'h0_0000_0000;
        #1;
        check("R5 combinational return", 32'(sum_out), 32'h0082);

        // R8: 17 terms in output 8 -> whole load refused
        build_a();
        for (int k = 30; k < 47; k++) mcfg[8][k] = 1'b1;
        mcfg[6][0] = 1'b1;
        shift_image();
        pulse_load();
        @(negedge clk);
        #1;
        check("R8 err on oversize mask", 32'(cfg_err), 32'h1);
        check("R8 refused load keeps sums", 32'(sum_out), 32'h0082);
        pt_in = 36'h0_0000_0001;
        #1;
        check("R8 refused load keeps out6", 32'(sum_out), 32'h009B);
        pt_in = '0;

        // R9: exactly 16 in output 8 accepted, err clears
        build_a();
        for (int k = 30; k < 46; k++) mcfg[8][k] = 1'b1;
        shift_image();
        pulse_load();
        @(negedge clk);
        #1;
        check("R9 err cleared", 32'(cfg_err), 32'h0);
        check("R8 sixteen terms accepted", 32'(sum_out), 32'h0182);

        // R10: reset again clears live config
        rst_n = 1'b0;
        #1;
        check("R10 sums in reset", 32'(sum_out), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule